// File: doc/BRIEF.md
# Dual-Port DRAM Access Arbiter

This block decides, cycle by cycle, which of three requesters owns a single DRAM controller: a refresh engine, access port A, or access port B. It drives a one-hot set of "run" outputs that tell the downstream timing sequencer which agent to serve, a steering bit that selects which port's external address buffers drive the shared address inputs, a wait signal per port for accesses that cannot proceed yet, and an early acknowledge for port B that fires once the sequencer reports row strobe active for the port B access.

A grant, once given, lasts as long as the owning request stays asserted; the arbiter re-decides only from its idle state, which is always visited for one cycle between two owners. A pending refresh beats a fresh port request but never cuts into a running access. When both ports ask at once, the port that is not the current steering holder wins. A lock input reserves the next grant for the port that currently holds the steering bit, so a port can chain several accesses while the other port waits.

Top module: `dram_port_arbiter`

## Requirements
- R1: After reset no run output is high, the steering bit grant_b is 0 (port A holds it) and ack_b is 0.
- R2: From idle, a lone port request makes that port's run output high at the next clock edge, and grant_b becomes 1 for port B or 0 for port A at that same edge.
- R3: From idle with both port requests high, no lock and no refresh, the port that does not hold grant_b wins.
- R4: From idle, a high refresh request wins over any port request, including a locked holder, and run_rf rises at the next edge.
- R5: A refresh request arriving while a port access runs does not end that access; the port keeps running while its request is high.
- R6: An owner keeps running while its request stays high; after the request drops the arbiter spends exactly one cycle idle (all run outputs low) before any new grant, and grant_b changes only on leaving idle.
- R7: wait_a is high exactly when a_req is high and run_a is low; wait_b likewise for port B.
- R8: ack_b is high exactly when run_b is high and ras_on is high.
- R9: From idle with lock high, only the port holding grant_b may be granted; a request from the other port is held off with its wait signal.
- R10: A refresh keeps ownership while rfsh_req stays high and releases it through the idle cycle once rfsh_req drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_req | input | 1 | Port A access request |
| b_req | input | 1 | Port B access request |
| rfsh_req | input | 1 | Refresh request |
| lock_in | input | 1 | Reserve next grant for current holder of grant_b |
| ras_on | input | 1 | Sequencer reports row strobe asserted |
| run_a | output | 1 | Port A owns the controller |
| run_b | output | 1 | Port B owns the controller |
| run_rf | output | 1 | Refresh owns the controller |
| grant_b | output | 1 | Address buffer steering: 1 selects port B |
| wait_a | output | 1 | Port A request is being held off |
| wait_b | output | 1 | Port B request is being held off |
| ack_b | output | 1 | Port B advanced acknowledge |

## Verification
Ownership and grant_b are registered, so a request change shows on run_* and grant_b one clock edge later, and a dropped request shows as the idle cycle one edge later with the next grant one edge after that. wait_a, wait_b and ack_b are combinational on the same cycle's inputs and ownership. The bench changes inputs just after the falling edge and compares every output against a behavioural model on each following falling edge, with directed checks placed at the falling edge that follows the rising edge where the change is due.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2,
        OWN_RF   = 2'd3
    } owner_t;

    typedef struct packed {
        logic rf;
        logic a;
        logic b;
    } req_t;

    // Winner among two port requests with no lock: the non-holder wins a tie.
    function automatic owner_t port_choice(input logic a, input logic b, input logic holder_b);
        owner_t w;
        if (a && b)
            w = holder_b ? OWN_A : OWN_B;
        else if (a)
            w = OWN_A;
        else if (b)
            w = OWN_B;
        else
            w = OWN_IDLE;
        return w;
    endfunction

endpackage

// File: rtl/dparb_pick.sv
module dparb_pick
    import dparb_pkg::*;
(
    input  req_t   req,
    input  logic   lock,
    input  logic   holder_b,
    output owner_t choice
);
    always_comb begin
        if (req.rf)
            choice = OWN_RF;
        else if (lock)
            choice = holder_b ? (req.b ? OWN_B : OWN_IDLE)
                              : (req.a ? OWN_A : OWN_IDLE);
        else
            choice = port_choice(req.a, req.b, holder_b);
    end
endmodule

// File: rtl/dparb_ctrl.sv
module dparb_ctrl
    import dparb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  req_t   req,
    input  logic   lock,
    input  owner_t choice,
    output owner_t state,
    output logic   holder_b
);
    owner_t state_nx;

    always_comb begin
        unique case (state)
            OWN_IDLE: state_nx = choice;
            OWN_A:    state_nx = req.a  ? OWN_A  : OWN_IDLE;
            OWN_B:    state_nx = req.b  ? OWN_B  : OWN_IDLE;
            OWN_RF:   state_nx = req.rf ? OWN_RF : OWN_IDLE;
            default:  state_nx = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= OWN_IDLE;
            holder_b <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == OWN_IDLE && choice == OWN_B)
                holder_b <= 1'b1;
            else if (state == OWN_IDLE && choice == OWN_A)
                holder_b <= 1'b0;
        end
    end

    assert_grant_moves_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(holder_b) |-> $past(state) == OWN_IDLE);

    assert_access_not_preempted_R5: assert property (@(posedge clk) disable iff (rst)
        (state == OWN_A && req.a) |=> state == OWN_A);

    assert_refresh_first_R4: assert property (@(posedge clk) disable iff (rst)
        (state == OWN_IDLE && req.rf) |=> state == OWN_RF);

    assert_lock_holds_a_R9: assert property (@(posedge clk) disable iff (rst)
        (state == OWN_IDLE && lock && !holder_b) |=> state != OWN_B);

    assert_lock_holds_b_R9: assert property (@(posedge clk) disable iff (rst)
        (state == OWN_IDLE && lock && holder_b) |=> state != OWN_A);

    assert_refresh_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (state == OWN_RF && req.rf) |=> state == OWN_RF);
endmodule

// File: rtl/dram_port_arbiter.sv
module dram_port_arbiter
    import dparb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_req,
    input  logic b_req,
    input  logic rfsh_req,
    input  logic lock_in,
    input  logic ras_on,
    output logic run_a,
    output logic run_b,
    output logic run_rf,
    output logic grant_b,
    output logic wait_a,
    output logic wait_b,
    output logic ack_b
);
    req_t   req;
    owner_t choice;
    owner_t state;
    logic   holder_b;

    assign req = '{rf: rfsh_req, a: a_req, b: b_req};

    dparb_pick u_pick (
        .req      (req),
        .lock     (lock_in),
        .holder_b (holder_b),
        .choice   (choice)
    );

    dparb_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .lock     (lock_in),
        .choice   (choice),
        .state    (state),
        .holder_b (holder_b)
    );

    assign run_a   = (state == OWN_A);
    assign run_b   = (state == OWN_B);
    assign run_rf  = (state == OWN_RF);
    assign grant_b = holder_b;
    assign wait_a  = a_req && !run_a;
    assign wait_b  = b_req && !run_b;
    assign ack_b   = run_b && ras_on;

    assert_ack_needs_owner_R8: assert property (@(posedge clk) disable iff (rst)
        ack_b |-> (run_b && ras_on));

    assert_owner_not_waiting_R7: assert property (@(posedge clk) disable iff (rst)
        (run_a |-> !wait_a) and (run_b |-> !wait_b));

    assert_single_owner_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({run_a, run_b, run_rf}));
endmodule

// File: tb/dram_port_arbiter_tb.sv
`timescale 1ns/1ps
module dram_port_arbiter_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_req = 0, b_req = 0, rfsh_req = 0, lock_in = 0, ras_on = 0;
    logic run_a, run_b, run_rf, grant_b, wait_a, wait_b, ack_b;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dram_port_arbiter u_dut (
        .clk(clk), .rst(rst), .a_req(a_req), .b_req(b_req), .rfsh_req(rfsh_req),
        .lock_in(lock_in), .ras_on(ras_on), .run_a(run_a), .run_b(run_b),
        .run_rf(run_rf), .grant_b(grant_b), .wait_a(wait_a), .wait_b(wait_b),
        .ack_b(ack_b)
    );

    // Behavioural reference: owner 0 none, 1 A, 2 B, 3 refresh; holder 0 A, 1 B.
    int m_own = 0;
    int m_hold = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_own = 0;
            m_hold = 0;
        end else if (m_own == 1) begin
            if (!a_req) m_own = 0;
        end else if (m_own == 2) begin
            if (!b_req) m_own = 0;
        end else if (m_own == 3) begin
            if (!rfsh_req) m_own = 0;
        end else begin
            int w;
            w = 0;
            if (rfsh_req) w = 3;
            else if (lock_in) w = (m_hold == 1) ? (b_req ? 2 : 0) : (a_req ? 1 : 0);
            else if (a_req && b_req) w = (m_hold == 1) ? 1 : 2;
            else if (a_req) w = 1;
            else if (b_req) w = 2;
            m_own = w;
            if (w == 1) m_hold = 0;
            if (w == 2) m_hold = 1;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R6 run_a",   run_a,  m_own == 1);
            check("R6 run_b",   run_b,  m_own == 2);
            check("R10 run_rf", run_rf, m_own == 3);
            check("R2 grant_b", grant_b, m_hold == 1);
            check("R7 wait_a",  wait_a, a_req && m_own != 1);
            check("R7 wait_b",  wait_b, b_req && m_own != 2);
            check("R8 ack_b",   ack_b,  (m_own == 2) && ras_on);
        end
    end

    task automatic drive(input logic a, input logic b, input logic rf, input logic lk, input logic rs);
        @(negedge clk);
        #1;
        a_req = a; b_req = b; rfsh_req = rf; lock_in = lk; ras_on = rs;
    endtask

    task automatic expect_own(input string tag, input logic ea, input logic eb, input logic erf);
        @(negedge clk);
        #2;
        check({tag, " run_a"}, run_a, ea);
        check({tag, " run_b"}, run_b, eb);
        check({tag, " run_rf"}, run_rf, erf);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 1'b0;
        // R1: reset state
        expect_own("R1", 0, 0, 0);
        check("R1 grant_b", grant_b, 1'b0);
        check("R1 ack_b", ack_b, 1'b0);

        // R2: lone port B request
        drive(0, 1, 0, 0, 0);
        expect_own("R2", 0, 1, 0);
        check("R2 grant_b", grant_b, 1'b1);
        // R8: early acknowledge with row strobe
        drive(0, 1, 0, 0, 1);
        #2 check("R8 ack_b", ack_b, 1'b1);
        // R6: drop B, A asks: idle cycle then A
        drive(1, 0, 0, 0, 0);
        #2 check("R7 wait_a", wait_a, 1'b1);
        expect_own("R6 idle", 0, 0, 0);
        expect_own("R6 grant", 1, 0, 0);
        check("R6 grant_b", grant_b, 1'b0);

        // R3: tie goes to non-holder (holder A -> B, then holder B -> A)
        drive(0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0);
        expect_own("R3 tie1", 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0);
        expect_own("R3 tie2", 1, 0, 0);

        // R4: refresh beats a port request from idle
        drive(0, 0, 0, 0, 0);
        drive(1, 0, 1, 0, 0);
        expect_own("R4", 0, 0, 1);
        check("R4 wait_a", wait_a, 1'b1);
        // R10: refresh holds then releases through idle
        drive(1, 0, 1, 0, 0);
        expect_own("R10 hold", 0, 0, 1);
        drive(1, 0, 0, 0, 0);
        expect_own("R10 idle", 0, 0, 0);
        expect_own("R10 next", 1, 0, 0);

        // R5: refresh does not preempt running A
        drive(1, 0, 1, 0, 0);
        expect_own("R5 a", 1, 0, 0);
        expect_own("R5 a2", 1, 0, 0);
        drive(0, 0, 1, 0, 0);
        expect_own("R5 idle", 0, 0, 0);
        expect_own("R5 rf", 0, 0, 1);
        drive(0, 0, 0, 0, 0);

        // R9: B holds with lock; A is held off
        drive(0, 1, 0, 0, 0);
        expect_own("R9 b", 0, 1, 0);
        drive(1, 0, 0, 1, 0);
        expect_own("R9 idle", 0, 0, 0);
        expect_own("R9 locked", 0, 0, 0);
        check("R9 wait_a", wait_a, 1'b1);
        drive(1, 1, 0, 1, 0);
        expect_own("R9 holder", 0, 1, 0);
        drive(1, 0, 0, 0, 0);
        expect_own("R9 release", 0, 0, 0);
        expect_own("R9 a", 1, 0, 0);

        // R4: refresh beats a locked holder
        drive(0, 0, 0, 1, 0);
        drive(1, 0, 1, 1, 0);
        expect_own("R4 lock", 0, 0, 1);
        drive(0, 0, 0, 0, 0);

        // Mixed pattern checked against the model
        for (int i = 0; i < 200; i++)
            drive((i % 3) == 0, (i % 5) < 2, (i % 17) == 4, (i % 11) > 7, i[0]);
        drive(0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule